// File: doc/BRIEF.md
# PHY Reset and Power-Down Controller

This block holds the reset and power state of the management registers of a multi-port Ethernet PHY. Each port has a control register and an advertisement register. At hardware reset the block loads their power-on defaults from per-port configuration strap pins and keeps a copy. A software reset, requested through a control-register bit, restores that saved copy and ignores any later change on the pins. The request bit stays set until the reset completes, so software can poll it.

The block also decides when management access is allowed. Access is closed for a fixed blanking interval after hardware reset and for as long as the global power-down pin is high. A per-port power-down only shuts down its own port. It drives the per-port output-enable and shutdown signals and a global clock-stop signal that the datapath would use.

Top module: `phy_rstpd_ctrl`

## Requirements
- R1: During hardware reset (rst_n low) each port's strap group (7 bits at strap_i[7p+6:7p]: bit 6 speed, bit 5 auto-negotiation enable, bit 4 duplex, bits 3:0 ability) is captured into control bit 13 (speed), bit 12 (auto-negotiation), bit 8 (duplex) and advertisement bits 8:5. Advertisement bits 4:0 read 5'b00001 and all other register bits read 0.
- R2: port_oe is all zero while rst_n is low and all ones once reset is released and power-down is low.
- R3: After reset release blank_busy stays high for exactly CLK_HZ/1000 cycles, counting the release cycle. A read issued while it is high returns 16'hFFFF with rd_err set, and a write issued then is dropped.
- R4: A read request (mgmt_req high, mgmt_we low) gives rd_valid with the data one cycle later. The control register is at address 0 and the advertisement register at address 4. Any other address reads 0 with no error. Writes give no rd_valid.
- R5: A write to address 0 updates bits 13, 12, 11 and 8, and a write to address 4 updates bits 8:5. The new value is visible to the next read.
- R6: Writing 1 to control bit 15 restores the strap bits saved at the last strap capture, ignoring the current pins. It also clears bit 11.
- R7: Bit 15 reads 1 for SRST_CYCLES cycles after the reset request and then 0. Registers stay readable during that time.
- R8: While pwr_down is high, port_oe is all zero, port_shutdown is all ones and clk_stop is 1. Reads return 16'hFFFF with rd_err set, and writes are dropped.
- R9: When pwr_down falls, the strap pins are captured again into both the registers and the saved copy, and bit 11 is cleared.
- R10: Control bit 11 raises port_shutdown for its own port only. port_oe stays high and that port's registers stay readable and writable.
- R11: Writes to a port are dropped while its software reset is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| pwr_down | input | 1 | Global power-down pin, high = powered down |
| strap_i | input | NPORTS*7 | Per-port configuration strap pins |
| mgmt_req | input | 1 | Management request strobe |
| mgmt_we | input | 1 | 1 = write, 0 = read |
| mgmt_port | input | $clog2(NPORTS) | Target port |
| mgmt_addr | input | 5 | Register address |
| mgmt_wdata | input | 16 | Write data |
| rd_valid | output | 1 | Read response valid |
| rd_data | output | 16 | Read response data |
| rd_err | output | 1 | Read was refused |
| blank_busy | output | 1 | Post-reset blanking interval running |
| clk_stop | output | 1 | Global clock stop |
| port_oe | output | NPORTS | Per-port output enable |
| port_shutdown | output | NPORTS | Per-port shutdown |

## Verification
The bench changes the strap pins after reset and then issues a software reset. A design that re-read the pins would return the new values instead of the saved ones. It counts the blanking cycles exactly, and issues a read and a write inside the interval. An off-by-one counter, or a design that let the write through, would show a wrong count or a changed register. It also writes during a running software reset, releases power-down and reads at once to check the strap reload, and powers down one port to check that the other port's shutdown and both output enables stay unchanged.

// File: rtl/phy_rstpd_pkg.sv
// Shared field positions and the strap record for the reset/power-down controller.
package phy_rstpd_pkg;
    localparam int STRAP_W    = 7;
    localparam int B_SRST     = 15;
    localparam int B_SPEED    = 13;
    localparam int B_ANEN     = 12;
    localparam int B_PDN      = 11;
    localparam int B_DUPLEX   = 8;
    localparam int ADV_LSB    = 5;
    localparam logic [4:0] ADV_SELECTOR = 5'b00001;
    localparam logic [4:0] ADDR_CTRL    = 5'd0;
    localparam logic [4:0] ADDR_ADV     = 5'd4;

    // Strap group of one port, MSB first: speed, aneg enable, duplex, ability.
    typedef struct packed {
        logic       speed;
        logic       anen;
        logic       duplex;
        logic [3:0] abil;
    } strap_t;
endpackage

// File: rtl/phy_rstpd_blank.sv
// Post-reset blanking timer: busy is high for BLANK cycles from reset release.
// Assumes BLANK >= 1.
module phy_rstpd_blank #(
    parameter int BLANK = 1000
) (
    input  logic clk,
    input  logic rst_n,
    output logic busy
);
    localparam int CW = $clog2(BLANK + 1);
    logic [CW-1:0] cnt;

    // Reload on reset, count down to zero afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= CW'(BLANK);
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);
endmodule

// File: rtl/phy_rstpd_port.sv
// One port's control and advertisement registers, strap capture and
// self-clearing software reset. Assumes writes arrive already gated for access.
module phy_rstpd_port
    import phy_rstpd_pkg::*;
#(
    parameter int SRST_CYCLES = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        pd_release,
    input  strap_t      strap_pin,
    input  logic        wr_ctrl,
    input  logic        wr_adv,
    input  logic [15:0] wdata,
    output logic [15:0] ctrl_rd,
    output logic [15:0] adv_rd,
    output logic        pdn
);
    localparam int SW = $clog2(SRST_CYCLES + 1);

    strap_t        saved;
    strap_t        live;
    logic          pdn_q;
    logic [SW-1:0] srst_cnt;
    logic          srst_busy;
    logic          unused_wbits;

    assign srst_busy    = (srst_cnt != '0);
    assign unused_wbits = ^{wdata[14], wdata[10:9], wdata[4:0]};

    // Capture straps, apply writes and run the software reset countdown.
    always_ff @(posedge clk) begin
        if (!rst_n || pd_release) begin
            saved    <= strap_pin;
            live     <= strap_pin;
            pdn_q    <= 1'b0;
            srst_cnt <= '0;
        end else begin
            if (srst_busy)
                srst_cnt <= srst_cnt - 1'b1;
            if (wr_ctrl && !srst_busy) begin
                if (wdata[B_SRST]) begin
                    live     <= saved;
                    pdn_q    <= 1'b0;
                    srst_cnt <= SW'(SRST_CYCLES);
                end else begin
                    live.speed  <= wdata[B_SPEED];
                    live.anen   <= wdata[B_ANEN];
                    live.duplex <= wdata[B_DUPLEX];
                    pdn_q       <= wdata[B_PDN];
                end
            end
            if (wr_adv && !srst_busy)
                live.abil <= wdata[ADV_LSB+3:ADV_LSB];
        end
    end

    // Assemble the read views of both registers.
    always_comb begin
        ctrl_rd           = '0;
        ctrl_rd[B_SRST]   = srst_busy;
        ctrl_rd[B_SPEED]  = live.speed;
        ctrl_rd[B_ANEN]   = live.anen;
        ctrl_rd[B_PDN]    = pdn_q;
        ctrl_rd[B_DUPLEX] = live.duplex;
        adv_rd            = '0;
        adv_rd[ADV_LSB+3:ADV_LSB] = live.abil;
        adv_rd[4:0]       = ADV_SELECTOR;
    end

    assign pdn = pdn_q;
endmodule

// File: rtl/phy_rstpd_access.sv
// Management access gate: decodes requests, drops blocked writes and returns
// registered read responses (all ones with error when blocked).
module phy_rstpd_access
    import phy_rstpd_pkg::*;
#(
    parameter int NPORTS = 2,
    parameter int PW     = 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    blocked,
    input  logic                    mgmt_req,
    input  logic                    mgmt_we,
    input  logic [PW-1:0]           mgmt_port,
    input  logic [4:0]              mgmt_addr,
    input  logic [NPORTS-1:0][15:0] ctrl_all,
    input  logic [NPORTS-1:0][15:0] adv_all,
    output logic [NPORTS-1:0]       wr_ctrl,
    output logic [NPORTS-1:0]       wr_adv,
    output logic                    rd_valid,
    output logic [15:0]             rd_data,
    output logic                    rd_err
);
    logic        port_ok;
    logic [15:0] sel_data;

    assign port_ok = (int'(mgmt_port) < NPORTS);

    // Per-port write strobes, only when access is open.
    always_comb begin
        wr_ctrl = '0;
        wr_adv  = '0;
        if (mgmt_req && mgmt_we && !blocked && port_ok) begin
            wr_ctrl[mgmt_port] = (mgmt_addr == ADDR_CTRL);
            wr_adv[mgmt_port]  = (mgmt_addr == ADDR_ADV);
        end
    end

    // Select the addressed register for a read.
    always_comb begin
        sel_data = '0;
        if (port_ok && mgmt_addr == ADDR_CTRL)
            sel_data = ctrl_all[mgmt_port];
        else if (port_ok && mgmt_addr == ADDR_ADV)
            sel_data = adv_all[mgmt_port];
    end

    // Register the read response one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
            rd_err   <= 1'b0;
        end else begin
            rd_valid <= mgmt_req && !mgmt_we;
            rd_err   <= mgmt_req && !mgmt_we && blocked;
            rd_data  <= blocked ? 16'hFFFF : sel_data;
        end
    end
endmodule

// File: rtl/phy_rstpd_ctrl.sv
// Top of the reset and power-down controller for NPORTS ports. Assumes
// NPORTS >= 2, pwr_down and straps synchronous to clk, CLK_HZ >= 1000.
module phy_rstpd_ctrl
    import phy_rstpd_pkg::*;
#(
    parameter int NPORTS      = 2,
    parameter int CLK_HZ      = 8_000_000,
    parameter int SRST_CYCLES = 8,
    localparam int PW         = $clog2(NPORTS),
    localparam int BLANK      = CLK_HZ / 1000
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    pwr_down,
    input  logic [NPORTS*STRAP_W-1:0] strap_i,
    input  logic                    mgmt_req,
    input  logic                    mgmt_we,
    input  logic [PW-1:0]           mgmt_port,
    input  logic [4:0]              mgmt_addr,
    input  logic [15:0]             mgmt_wdata,
    output logic                    rd_valid,
    output logic [15:0]             rd_data,
    output logic                    rd_err,
    output logic                    blank_busy,
    output logic                    clk_stop,
    output logic [NPORTS-1:0]       port_oe,
    output logic [NPORTS-1:0]       port_shutdown
);
    logic                    pd_q;
    logic                    pd_release;
    logic [NPORTS-1:0][15:0] ctrl_all;
    logic [NPORTS-1:0][15:0] adv_all;
    logic [NPORTS-1:0]       wr_ctrl;
    logic [NPORTS-1:0]       wr_adv;
    logic [NPORTS-1:0]       pdn;

    // Remember the power-down pin to find its release.
    always_ff @(posedge clk) begin
        if (!rst_n) pd_q <= 1'b0;
        else        pd_q <= pwr_down;
    end
    assign pd_release = pd_q && !pwr_down;

    phy_rstpd_blank #(.BLANK(BLANK)) u_blank (
        .clk(clk), .rst_n(rst_n), .busy(blank_busy)
    );

    phy_rstpd_access #(.NPORTS(NPORTS), .PW(PW)) u_access (
        .clk(clk), .rst_n(rst_n), .blocked(blank_busy || pwr_down),
        .mgmt_req(mgmt_req), .mgmt_we(mgmt_we), .mgmt_port(mgmt_port),
        .mgmt_addr(mgmt_addr), .ctrl_all(ctrl_all), .adv_all(adv_all),
        .wr_ctrl(wr_ctrl), .wr_adv(wr_adv),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_err(rd_err)
    );

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        phy_rstpd_port #(.SRST_CYCLES(SRST_CYCLES)) u_port (
            .clk(clk), .rst_n(rst_n), .pd_release(pd_release),
            .strap_pin(strap_t'(strap_i[p*STRAP_W +: STRAP_W])),
            .wr_ctrl(wr_ctrl[p]), .wr_adv(wr_adv[p]), .wdata(mgmt_wdata),
            .ctrl_rd(ctrl_all[p]), .adv_rd(adv_all[p]), .pdn(pdn[p])
        );
    end

    assign clk_stop      = pwr_down;
    assign port_oe       = {NPORTS{rst_n && !pwr_down}};
    assign port_shutdown = pdn | {NPORTS{pwr_down}};
endmodule

// File: rtl/phy_rstpd_chk.sv
// Property checker for phy_rstpd_ctrl, attached by bind below.
module phy_rstpd_chk #(
    parameter int NPORTS = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pwr_down,
    input logic              mgmt_req,
    input logic              mgmt_we,
    input logic              rd_valid,
    input logic [15:0]       rd_data,
    input logic              rd_err,
    input logic              blank_busy,
    input logic              clk_stop,
    input logic [NPORTS-1:0] port_oe,
    input logic [NPORTS-1:0] port_shutdown
);
    assert_blocked_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mgmt_req && !mgmt_we && (blank_busy || pwr_down)) |=>
        (rd_valid && rd_err && rd_data == 16'hFFFF));

    assert_busy_no_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(blank_busy));

    assert_open_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mgmt_req && !mgmt_we && !blank_busy && !pwr_down) |=> (rd_valid && !rd_err));

    assert_no_resp_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!mgmt_req || mgmt_we) |=> !rd_valid);

    assert_pd_outputs_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |-> (port_oe == '0 && port_shutdown == {NPORTS{1'b1}} && clk_stop));

    assert_oe_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_down |-> (port_oe == {NPORTS{1'b1}}));

    // R2: outputs disabled throughout hardware reset.
    always @(posedge clk) begin
        if (!rst_n) assert_oe_reset_R2: assert (port_oe == '0);
    end
endmodule

bind phy_rstpd_ctrl phy_rstpd_chk #(.NPORTS(NPORTS)) u_chk (
    .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down), .mgmt_req(mgmt_req),
    .mgmt_we(mgmt_we), .rd_valid(rd_valid), .rd_data(rd_data), .rd_err(rd_err),
    .blank_busy(blank_busy), .clk_stop(clk_stop), .port_oe(port_oe),
    .port_shutdown(port_shutdown)
);

// File: tb/phy_rstpd_ctrl_bench.sv
// Scoreboard bench: read tasks queue expected responses, a monitor pops them.
module phy_rstpd_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NP         = 2;
    localparam int HZ         = 20_000;
    localparam int BLANK_EXP  = HZ / 1000;
    localparam int SRC        = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pwr_down = 1'b0;
    logic [13:0]   strap_i = '0;
    logic          mgmt_req = 1'b0, mgmt_we = 1'b0;
    logic [0:0]    mgmt_port = '0;
    logic [4:0]    mgmt_addr = '0;
    logic [15:0]   mgmt_wdata = '0;
    logic          rd_valid, rd_err, blank_busy, clk_stop;
    logic [15:0]   rd_data;
    logic [NP-1:0] port_oe, port_shutdown;

    int checks = 0, failures = 0;
    logic [16:0] exp_q[$];
    string       rid_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    phy_rstpd_ctrl #(.NPORTS(NP), .CLK_HZ(HZ), .SRST_CYCLES(SRC)) u_phy_rstpd_ctrl (
        .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down), .strap_i(strap_i),
        .mgmt_req(mgmt_req), .mgmt_we(mgmt_we), .mgmt_port(mgmt_port),
        .mgmt_addr(mgmt_addr), .mgmt_wdata(mgmt_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_err(rd_err),
        .blank_busy(blank_busy), .clk_stop(clk_stop),
        .port_oe(port_oe), .port_shutdown(port_shutdown)
    );

    localparam logic [6:0] S1P0 = 7'b1101010, S1P1 = 7'b0110101;
    localparam logic [6:0] S2P0 = 7'b0011111, S2P1 = 7'b1000011;

    function automatic logic [15:0] ctrl_of(logic [6:0] s);
        return (16'(s[6]) << 13) | (16'(s[5]) << 12) | (16'(s[4]) << 8);
    endfunction
    function automatic logic [15:0] adv_of(logic [6:0] s);
        return (16'(s[3:0]) << 5) | 16'h0001;
    endfunction

    task automatic check(string rid, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", rid, act, exp);
        end
    endtask

    // Driver: read request, expected response pushed to the scoreboard.
    task automatic rd(int port, logic [4:0] addr, logic [15:0] ed, logic ee, string rid);
        mgmt_req = 1'b1; mgmt_we = 1'b0; mgmt_port = 1'(port); mgmt_addr = addr;
        exp_q.push_back({ee, ed});
        rid_q.push_back(rid);
        @(negedge clk);
        mgmt_req = 1'b0;
    endtask

    task automatic wr(int port, logic [4:0] addr, logic [15:0] d);
        mgmt_req = 1'b1; mgmt_we = 1'b1; mgmt_port = 1'(port); mgmt_addr = addr;
        mgmt_wdata = d;
        @(negedge clk);
        mgmt_req = 1'b0; mgmt_we = 1'b0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Monitor: compare every read response against the scoreboard.
    always @(negedge clk) begin
        if (rd_valid) begin
            if (exp_q.size() == 0) begin
                checks++; failures++;
                $display("FAIL R4 unexpected rd_valid actual=%h expected=none", rd_data);
            end else begin
                logic [16:0] e;
                string r;
                e = exp_q.pop_front();
                r = rid_q.pop_front();
                check(r, {15'd0, rd_err, rd_data}, {15'd0, e});
            end
        end
    end

    task automatic finish_run;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        checks++; failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        int cnt;
        strap_i = {S1P1, S1P0};
        idle(5);
        check("R2 oe in reset", 32'(port_oe), 32'd0);
        check("R4 no rd_valid in reset", 32'(rd_valid), 32'd0);
        rst_n = 1'b1;
        cnt = 0;
        while (blank_busy && cnt < 1000) begin cnt++; @(negedge clk); end
        check("R3 blanking length", 32'(cnt), 32'(BLANK_EXP));
        check("R2 oe after reset", 32'(port_oe), 32'h3);
        // R1 strap capture, R4 layout
        rd(0, 5'd0, ctrl_of(S1P0), 1'b0, "R1 ctrl p0");
        rd(0, 5'd4, adv_of(S1P0), 1'b0, "R1 adv p0");
        rd(1, 5'd0, ctrl_of(S1P1), 1'b0, "R1 ctrl p1");
        rd(1, 5'd4, adv_of(S1P1), 1'b0, "R1 adv p1");
        rd(1, 5'd2, 16'h0000, 1'b0, "R4 unmapped address");
        // R5 writes
        wr(0, 5'd0, 16'h0000);
        rd(0, 5'd0, 16'h0000, 1'b0, "R5 ctrl write");
        wr(1, 5'd4, 16'h0180);
        rd(1, 5'd4, 16'h0181, 1'b0, "R5 adv write");
        // R6/R7/R11 software reset with changed pins
        strap_i = {S2P1, S2P0};
        wr(0, 5'd0, 16'h8000);
        rd(0, 5'd0, ctrl_of(S1P0) | 16'h8000, 1'b0, "R7 bit15 set while running");
        wr(0, 5'd0, 16'h2100);
        idle(SRC + 2);
        rd(0, 5'd0, ctrl_of(S1P0), 1'b0, "R6 R11 restored and write dropped");
        rd(0, 5'd4, adv_of(S1P0), 1'b0, "R6 adv restored");
        // R10 per-port power-down
        wr(1, 5'd0, ctrl_of(S1P1) | 16'h0800);
        check("R10 shutdown only port1", 32'(port_shutdown), 32'h2);
        check("R10 oe kept", 32'(port_oe), 32'h3);
        rd(1, 5'd0, ctrl_of(S1P1) | 16'h0800, 1'b0, "R10 registers readable");
        // R8 global power-down
        pwr_down = 1'b1;
        @(negedge clk);
        check("R8 oe off", 32'(port_oe), 32'h0);
        check("R8 shutdown all", 32'(port_shutdown), 32'h3);
        check("R8 clk_stop", 32'(clk_stop), 32'h1);
        rd(0, 5'd0, 16'hFFFF, 1'b1, "R8 read blocked");
        wr(0, 5'd0, 16'h3100);
        idle(2);
        pwr_down = 1'b0;
        @(negedge clk);
        // R9 reload from current pins
        rd(0, 5'd0, ctrl_of(S2P0), 1'b0, "R9 ctrl p0 reloaded");
        rd(1, 5'd0, ctrl_of(S2P1), 1'b0, "R9 ctrl p1 reloaded, bit11 clear");
        rd(1, 5'd4, adv_of(S2P1), 1'b0, "R9 adv p1 reloaded");
        check("R9 shutdown cleared", 32'(port_shutdown), 32'h0);
        // R3 access during blanking after a second hardware reset
        rst_n = 1'b0;
        idle(3);
        rst_n = 1'b1;
        rd(0, 5'd0, 16'hFFFF, 1'b1, "R3 read during blanking");
        wr(0, 5'd0, 16'h0000);
        while (blank_busy) @(negedge clk);
        rd(0, 5'd0, ctrl_of(S2P0), 1'b0, "R3 write during blanking dropped");
        idle(3);
        check("R4 scoreboard drained", 32'(exp_q.size()), 32'd0);
        finish_run();
    end
endmodule